// File: doc/BRIEF.md
# Daisy-Chain Converter Readback Controller

This block sits on the host side of a string of identical 16-bit serial converters that share one convert strobe and one serial clock, with each converter's data output feeding the data input of the next and the last one's output returning to the host. When the surrounding logic requests a sample, the controller raises the convert strobe and holds it high until readback ends. The level of the serial clock at the moment the strobe rises tells the converters whether a busy start bit is wanted. The controller then waits for the conversion. It either counts a fixed worst-case conversion time, or, in busy mode, keeps the serial clock high and watches the returned data line for the start bit.

It then generates the serial clock by dividing the system clock. It samples the returned line one system cycle before each falling edge and slices the stream into one word per converter. Each word comes out with its position in the chain, and a frame-done pulse closes the frame. If the busy start bit never shows up, the controller abandons the frame and flags an error. Successive convert strobes are always kept a configurable minimum number of cycles apart, even when requests arrive back to back.

Parameters: `NUM_DEV` (converters in the chain), `CLK_DIV` (system cycles per serial clock half period), `CONV_CYC` (fixed wait in system cycles), `CYCLE_CYC` (minimum spacing of convert strobe rises), `BUSY_TMO` (busy wait limit).

Top module: `adc_chain_reader`

## Requirements
- R1: After reset `cnv`, `sck`, `word_valid`, `frame_done` and `busy_err` are 0, and `cnv` stays 0 while no request is made. During a frame `cnv` stays high from its rise until one cycle after the last `sck` falling edge, and then drops for good.
- R2: A request is taken when `start` is 1 in idle. `cnv` rises two cycles later. At that rise `sck` equals the value of `use_busy` captured at acceptance (1 = busy mode, 0 = fixed wait).
- R3: In fixed-wait mode `sck` is low from the `cnv` rise. Its first falling edge comes exactly `CONV_CYC + 2*CLK_DIV` cycles after that rise.
- R4: In busy mode `sck` stays high while `sdo_in` is low. Once `sdo_in` is seen high, the first `sck` falling edge follows one cycle after that sampling edge. The bit sampled there is the start bit and is discarded.
- R5: A frame has exactly `16*NUM_DEV` `sck` falling edges in fixed-wait mode and `16*NUM_DEV+1` in busy mode.
- R6: Each word is assembled MSB first from `sdo_in`, sampled one system cycle before a falling edge. The first 16 data bits form word index 0 (the converter nearest the host), the next 16 form index 1, and so on.
- R7: `word_valid` pulses once per word, with `word_idx` running 0 to `NUM_DEV-1` in order. `frame_done` pulses for one cycle, one cycle after the last `word_valid`.
- R8: Rising edges of `cnv` are at least `CYCLE_CYC` cycles apart. With `start` held high they are exactly `CYCLE_CYC` apart whenever the frame is shorter than that.
- R9: In busy mode, if `sdo_in` is not seen high within `BUSY_TMO` cycles of the `cnv` rise, `busy_err` pulses for one cycle exactly `BUSY_TMO` cycles after the rise. In the same cycle `cnv` and `sck` fall, and the frame produces no word and no `frame_done`.
- R10: `start` has no effect while a frame is in progress: holding it high through a frame produces exactly one `cnv` rise for that frame.
- R11: Successive `sck` falling edges within a frame are exactly `2*CLK_DIV` cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Sample request, level sensitive |
| use_busy | input | 1 | 1 selects busy start-bit mode for the next frame |
| sdo_in | input | 1 | Serial data returned from the end of the chain |
| cnv | output | 1 | Convert strobe to all converters |
| sck | output | 1 | Serial clock to all converters |
| word_valid | output | 1 | One-cycle strobe for a completed word |
| word_data | output | 16 | Completed word, two's complement as received |
| word_idx | output | IDX_W | Chain position of the word, 0 = nearest |
| frame_done | output | 1 | One-cycle pulse after the last word |
| busy_err | output | 1 | One-cycle pulse when the busy bit times out |

## Verification
The bench aims at the edges of the busy wait. It uses a start bit that arrives on the very last allowed cycle, one that arrives one cycle after the rise, and one that never arrives. A design that is off by one in the timeout comparison would abort the boundary frame or report the error a cycle late. Words made only of edge values (0x8000, 0x7FFF, 0xFFFF, 0x0000) and mixed-mode random frames show any slip of the discarded start bit, because a design that kept it, or dropped a data bit instead, shifts every word by one position. Requests held high across several frames check the strobe spacing and that an in-progress frame ignores `start`.

// File: rtl/adc_chain_pkg.sv
package adc_chain_pkg;

  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CONV,
    ST_WAITB,
    ST_SHIFT,
    ST_DONE
  } acr_state_e;

  // serial clock falling edges needed for one frame
  function automatic int pulse_total(int n_dev, logic busy);
    return WORD_W * n_dev + (busy ? 1 : 0);
  endfunction

  // data bit position of a pulse; negative for the busy start bit
  function automatic int data_pos(int pulse, logic busy);
    return busy ? pulse - 1 : pulse;
  endfunction

endpackage

// File: rtl/acr_count.sv
module acr_count #(
  parameter int MAXV     = 100,
  parameter bit RST_FULL = 1'b0,
  localparam int W       = $clog2(MAXV + 2)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = W'(MAXV);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= RST_FULL ? TOP : '0;
    else if (clr)        cnt <= '0;
    else if (cnt != TOP) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/acr_deser.sv
module acr_deser #(
  parameter int IDX_W  = 2,
  parameter int WORD_W = 16,
  localparam int BW    = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp,
  input  logic              keep,
  input  logic              bit_in,
  input  logic [BW-1:0]     bit_pos,
  input  logic [IDX_W-1:0]  idx_in,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  output logic [IDX_W-1:0]  word_idx
);
  logic [WORD_W-2:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh         <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
      word_idx   <= '0;
    end else begin
      word_valid <= 1'b0;
      if (smp && keep) begin
        sh <= {sh[WORD_W-3:0], bit_in};
        if (bit_pos == BW'(WORD_W - 1)) begin
          word_valid <= 1'b1;
          word_data  <= {sh, bit_in};
          word_idx   <= idx_in;
        end
      end
    end
  end
endmodule

// File: rtl/adc_chain_reader.sv
module adc_chain_reader
  import adc_chain_pkg::*;
#(
  parameter int NUM_DEV   = 3,
  parameter int CLK_DIV   = 2,
  parameter int CONV_CYC  = 80,
  parameter int CYCLE_CYC = 100,
  parameter int BUSY_TMO  = 200,
  localparam int IDX_W    = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              use_busy,
  input  logic              sdo_in,
  output logic              cnv,
  output logic              sck,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  output logic [IDX_W-1:0]  word_idx,
  output logic              frame_done,
  output logic              busy_err
);
  localparam int PMAX    = WORD_W * NUM_DEV + 1;
  localparam int PW      = $clog2(PMAX + 1);
  localparam int PHW     = $clog2(2 * CLK_DIV + 1);
  localparam int WT_MAX  = (CONV_CYC > BUSY_TMO) ? CONV_CYC : BUSY_TMO;
  localparam int WTW     = $clog2(WT_MAX + 2);
  localparam int GAP_LIM = (CYCLE_CYC > 2) ? CYCLE_CYC - 2 : 0;
  localparam int GW      = $clog2(GAP_LIM + 2);
  localparam int BW      = $clog2(WORD_W);

  acr_state_e     state;
  logic           mode_q;
  logic [PHW-1:0] ph;
  logic [PW-1:0]  pcnt;
  logic           err_q, fd_q;
  logic [WTW-1:0] wcnt;
  logic [GW-1:0]  gcnt;

  // named internal events
  logic launch_evt, conv_end_evt, busy_seen_evt, tmo_evt, smp_evt, last_evt;
  logic gap_ok, keep_bit;
  int   dpos;

  acr_count #(.MAXV(WT_MAX), .RST_FULL(1'b0)) u_wait (
    .clk(clk), .rst_n(rst_n),
    .clr(!(state == ST_CONV || state == ST_WAITB)), .cnt(wcnt));

  acr_count #(.MAXV(GAP_LIM), .RST_FULL(1'b1)) u_gap (
    .clk(clk), .rst_n(rst_n), .clr(state == ST_SETUP), .cnt(gcnt));

  always_comb begin
    gap_ok        = gcnt >= GW'(GAP_LIM);
    launch_evt    = (state == ST_IDLE) && start && gap_ok;
    conv_end_evt  = (state == ST_CONV) && (wcnt == WTW'(CONV_CYC - 1));
    busy_seen_evt = (state == ST_WAITB) && sdo_in;
    tmo_evt       = (state == ST_WAITB) && !sdo_in && (wcnt == WTW'(BUSY_TMO - 1));
    smp_evt       = (state == ST_SHIFT) && (ph == PHW'(2 * CLK_DIV - 1));
    last_evt      = smp_evt && (pcnt == PW'(pulse_total(NUM_DEV, mode_q) - 1));
    dpos          = data_pos(int'(pcnt), mode_q);
    keep_bit      = (dpos >= 0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      mode_q <= 1'b0;
      ph     <= '0;
      pcnt   <= '0;
      err_q  <= 1'b0;
      fd_q   <= 1'b0;
    end else begin
      err_q <= tmo_evt;
      fd_q  <= (state == ST_DONE);
      case (state)
        ST_IDLE: if (launch_evt) begin
          state  <= ST_SETUP;
          mode_q <= use_busy;
        end
        ST_SETUP: state <= mode_q ? ST_WAITB : ST_CONV;
        ST_CONV: if (conv_end_evt) begin
          state <= ST_SHIFT;
          ph    <= '0;
          pcnt  <= '0;
        end
        ST_WAITB: begin
          if (busy_seen_evt) begin
            state <= ST_SHIFT;
            ph    <= PHW'(2 * CLK_DIV - 1);
            pcnt  <= '0;
          end else if (tmo_evt) begin
            state <= ST_IDLE;
          end
        end
        ST_SHIFT: begin
          if (smp_evt) begin
            ph   <= '0;
            pcnt <= pcnt + 1'b1;
            if (last_evt) state <= ST_DONE;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_SETUP: sck = mode_q;
      ST_WAITB: sck = 1'b1;
      ST_SHIFT: sck = (ph >= PHW'(CLK_DIV));
      default:  sck = 1'b0;
    endcase
  end

  assign cnv        = (state == ST_CONV) || (state == ST_WAITB) ||
                      (state == ST_SHIFT) || (state == ST_DONE);
  assign frame_done = fd_q;
  assign busy_err   = err_q;

  acr_deser #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_deser (
    .clk(clk), .rst_n(rst_n),
    .smp(smp_evt), .keep(keep_bit), .bit_in(sdo_in),
    .bit_pos(BW'(dpos % WORD_W)), .idx_in(IDX_W'(dpos / WORD_W)),
    .word_valid(word_valid), .word_data(word_data), .word_idx(word_idx));

endmodule

// File: rtl/acr_checker.sv
module acr_checker #(
  parameter int NUM_DEV   = 3,
  parameter int CYCLE_CYC = 100,
  parameter int IDX_W     = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnv,
  input logic             sck,
  input logic             mode,
  input logic             word_valid,
  input logic [IDX_W-1:0] word_idx,
  input logic             frame_done,
  input logic             busy_err
);
  localparam int SW = $clog2(CYCLE_CYC + 2);
  localparam int FW = $clog2(16 * NUM_DEV + 3);

  logic          cnv_d, sck_d;
  logic [SW-1:0] since;
  logic [FW-1:0] falls;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnv_d <= 1'b0;
      sck_d <= 1'b0;
      since <= SW'(CYCLE_CYC);
      falls <= '0;
    end else begin
      cnv_d <= cnv;
      sck_d <= sck;
      if (cnv && !cnv_d)                 since <= SW'(1);
      else if (since != SW'(CYCLE_CYC))  since <= since + 1'b1;
      if (cnv && !cnv_d)                 falls <= '0;
      else if (sck_d && !sck && cnv)     falls <= falls + 1'b1;
    end
  end

  // R2
  rise_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv) |-> sck == mode);

  // R1
  fall_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |-> (cnv || busy_err));

  // R8
  gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv && !cnv_d) |-> since >= SW'(CYCLE_CYC));

  // R5
  pulses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> falls == FW'(16 * NUM_DEV + (mode ? 1 : 0)));

  // R7
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(word_valid) && ($past(word_idx) == IDX_W'(NUM_DEV - 1)));

  // R9
  err_cnv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_err |-> !cnv && !word_valid && !frame_done);
endmodule

bind adc_chain_reader acr_checker #(
  .NUM_DEV(NUM_DEV), .CYCLE_CYC(CYCLE_CYC), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cnv(cnv), .sck(sck), .mode(mode_q),
  .word_valid(word_valid), .word_idx(word_idx),
  .frame_done(frame_done), .busy_err(busy_err));

// File: tb/tb_adc_chain_reader.sv
module tb_adc_chain_reader;
  localparam int N    = 2;
  localparam int DIV  = 2;
  localparam int CONV = 80;
  localparam int CYC  = 300;
  localparam int TMO  = 150;
  localparam int IDXW = (N > 1) ? $clog2(N) : 1;
  localparam int NEVER = 1000000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, use_busy = 1'b0;
  logic cnv, sck, word_valid, frame_done, busy_err, sdo_m;
  logic [15:0] word_data;
  logic [IDXW-1:0] word_idx;

  always #10 clk = ~clk;

  adc_chain_reader #(.NUM_DEV(N), .CLK_DIV(DIV), .CONV_CYC(CONV),
                     .CYCLE_CYC(CYC), .BUSY_TMO(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .use_busy(use_busy),
    .sdo_in(sdo_m), .cnv(cnv), .sck(sck), .word_valid(word_valid),
    .word_data(word_data), .word_idx(word_idx),
    .frame_done(frame_done), .busy_err(busy_err));

  // ---------------- converter chain model ----------------
  logic [15:0]   mw [N];
  logic [16*N:0] full;
  logic          mbusy = 1'b0, mdone = 1'b0;
  int            mdelay = 1;
  int            k = 0;
  int            pos_m;

  always @(posedge cnv) begin
    mbusy = sck;
    k     = 0;
    mdone = 1'b0;
    if (mdelay < NEVER) begin
      repeat (mdelay) @(negedge clk);
      mdone = 1'b1;
    end
  end

  always @(negedge sck) if (cnv) k = k + 1;

  always_comb begin
    pos_m = 16 * N - k - (mbusy ? 0 : 1);
    sdo_m = (mdone && pos_m >= 0) ? full[pos_m] : 1'b0;
  end

  // ---------------- monitor ----------------
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic prev_sck = 1'b0, prev_cnv = 1'b0;
  int nrise, nfall, first_fall, last_fall, spacing_bad, nwords, ord_bad;
  int fd_cnt, fd_cyc, last_valid_cyc, err_cnt, err_cyc, ncnv_fall, cnv_fall_cyc;
  int rise_cyc, rise_mode_bad;
  int rises [4];
  logic [15:0] rw [N];
  logic exp_mode;

  always @(negedge clk) begin
    if (cnv && !prev_cnv) begin
      if (nrise < 4) rises[nrise] = cyc;
      rise_cyc = cyc;
      nrise++;
      if (sck !== exp_mode) rise_mode_bad++;
    end
    if (!cnv && prev_cnv) begin
      ncnv_fall++;
      cnv_fall_cyc = cyc;
    end
    if (prev_sck && !sck && cnv) begin
      nfall++;
      if (nfall == 1) first_fall = cyc;
      else if (cyc - last_fall != 2 * DIV) spacing_bad++;
      last_fall = cyc;
    end
    if (word_valid) begin
      if (int'(word_idx) != nwords) ord_bad++;
      if (int'(word_idx) < N) rw[word_idx] = word_data;
      nwords++;
      last_valid_cyc = cyc;
    end
    if (frame_done) begin fd_cnt++; fd_cyc = cyc; end
    if (busy_err)   begin err_cnt++; err_cyc = cyc; end
    prev_sck = sck;
    prev_cnv = cnv;
  end

  // ---------------- scoring ----------------
  int nchk = 0, nfail = 0;

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    nrise = 0; nfall = 0; first_fall = 0; last_fall = 0; spacing_bad = 0;
    nwords = 0; ord_bad = 0; fd_cnt = 0; fd_cyc = 0; last_valid_cyc = 0;
    err_cnt = 0; err_cyc = 0; ncnv_fall = 0; cnv_fall_cyc = 0;
    rise_cyc = 0; rise_mode_bad = 0;
    for (int i = 0; i < N; i++) rw[i] = 16'hxxxx;
  endtask

  function automatic int exp_pulses(input logic busy);
    return 16 * N + (busy ? 1 : 0);
  endfunction

  task automatic load_words(input logic [15:0] a, input logic [15:0] b);
    mw[0] = a;
    mw[1] = b;
    full[16*N] = 1'b1;
    for (int i = 0; i < N; i++) full[16*N-1-16*i -: 16] = mw[i];
  endtask

  task automatic wait_end();
    for (int t = 0; t < 3000 && fd_cnt == 0 && err_cnt == 0; t++) @(negedge clk);
    @(posedge clk); #2 start = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_frame(input logic busy, input int delay,
                           input logic [15:0] a, input logic [15:0] b);
    @(posedge clk); #2;
    load_words(a, b);
    mdelay = delay;
    exp_mode = busy;
    clear_mon();
    use_busy = busy;
    start = 1'b1;
    wait_end();
    chk(nrise == 1, "R10 one cnv rise per held request", nrise, 1);
    chk(rise_mode_bad == 0, "R2 sck level at cnv rise", rise_mode_bad, 0);
    if (busy && delay > TMO) begin
      chk(err_cnt == 1 && err_cyc - rise_cyc == TMO, "R9 busy_err timing",
          err_cyc - rise_cyc, TMO);
      chk(nwords == 0 && fd_cnt == 0, "R9 no words after timeout", nwords, 0);
      chk(ncnv_fall == 1 && cnv_fall_cyc == err_cyc, "R9 cnv drops with error",
          cnv_fall_cyc, err_cyc);
    end else begin
      if (busy)
        chk(first_fall - rise_cyc == delay + 1, "R4 first fall after start bit",
            first_fall - rise_cyc, delay + 1);
      else
        chk(first_fall - rise_cyc == CONV + 2 * DIV, "R3 fixed wait to first fall",
            first_fall - rise_cyc, CONV + 2 * DIV);
      chk(nfall == exp_pulses(busy), "R5 falling edge count", nfall, exp_pulses(busy));
      chk(spacing_bad == 0, "R11 sck period", spacing_bad, 0);
      for (int i = 0; i < N; i++)
        chk(rw[i] === mw[i], $sformatf("R6 word %0d", i), rw[i], mw[i]);
      chk(nwords == N && ord_bad == 0, "R7 word count and order", nwords, N);
      chk(fd_cnt == 1 && fd_cyc == last_valid_cyc + 1, "R7 frame_done after last word",
          fd_cyc, last_valid_cyc + 1);
      chk(ncnv_fall == 1 && cnv_fall_cyc == last_fall + 1, "R1 cnv held through readback",
          cnv_fall_cyc, last_fall + 1);
      chk(err_cnt == 0, "R9 no error on good frame", err_cnt, 0);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    void'($urandom(32'h1234_abcd));
    full = '0;
    exp_mode = 1'b0;
    clear_mon();
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk({cnv, sck, word_valid, frame_done, busy_err} == 5'b0, "R1 reset state",
        {cnv, sck, word_valid, frame_done, busy_err}, 0);
    repeat (40) @(negedge clk);
    chk(cnv == 1'b0 && nrise == 0, "R1 idle without request", nrise, 0);

    // directed corners
    run_frame(1'b0, 5, 16'h8000, 16'h7FFF);
    run_frame(1'b1, 1, 16'hFFFF, 16'h0000);
    run_frame(1'b1, TMO, 16'h0001, 16'hFFFE);
    run_frame(1'b1, NEVER, 16'h1234, 16'h5678);
    run_frame(1'b0, CONV - 1, 16'hA5A5, 16'h5A5A);

    // constrained random frames
    for (int f = 0; f < 10; f++) begin
      logic b;
      int d;
      b = 1'(($urandom() >> 3) & 1);
      d = b ? 1 + int'($urandom() % (TMO - 1)) : 1 + int'($urandom() % (CONV - 1));
      run_frame(b, d, 16'($urandom()), 16'($urandom()));
    end

    // back-to-back requests
    @(posedge clk); #2;
    load_words(16'h0F0F, 16'hF0F0);
    mdelay = 3;
    exp_mode = 1'b0;
    clear_mon();
    use_busy = 1'b0;
    start = 1'b1;
    for (int t = 0; t < 3000 && nrise < 3; t++) @(negedge clk);
    for (int t = 0; t < 3000 && fd_cnt < 3; t++) @(negedge clk);
    @(posedge clk); #2 start = 1'b0;
    repeat (4) @(negedge clk);
    chk(rises[1] - rises[0] == CYC, "R8 cnv spacing 1", rises[1] - rises[0], CYC);
    chk(rises[2] - rises[1] == CYC, "R8 cnv spacing 2", rises[2] - rises[1], CYC);
    chk(fd_cnt == 3 && nwords == 3 * N, "R7 three held frames complete", fd_cnt, 3);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule